// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a system-monitor watchdog for a small 8-bit controller. Software reaches it through one control byte on a simple special-function-register read/write port. A machine-cycle strobe arrives once per instruction cycle, which is the oscillator divided by twelve. While the watchdog is enabled, each strobe advances a prescaler with a selectable divide ratio. Each prescaler terminal count advances a wide timer. When that timer overflows, the block issues a reset request to the rest of the chip.

Software keeps the system alive by writing the clear bit before the timer overflows. The clear takes effect on the next machine cycle. A separate control bit decides whether the watchdog keeps counting while the controller sits in idle mode. The reset request also returns the watchdog itself to its disabled reset state.

Top module: `wdt_prescaled`

## Requirements
- R1: The control byte answers only at address `REG_ADDR` (default 8Fh). Its layout is: bit 7 enable, bit 6 clear, bit 5 run-in-idle, bits 2:0 prescaler select. Bits 4 and 3 are ignored on write and read as 0. A read at any other address returns 00h.
- R2: After reset the control byte reads 00h and the reset request is low.
- R3: Prescaler select codes map to divide ratios as follows: 000→2, 010→4, 001→8, 011→16, 100→32, 101→64, 110→128, 111→256. The reset request rises right after the ratio × 2^TMR_W-th counted machine-cycle strobe following enable, and not before.
- R4: While enable is 0, strobes are not counted and no reset request is raised.
- R5: Writing 1 to the clear bit makes that bit read 1 until the next strobe. That strobe is not counted: it zeroes the prescaler, the timer and the clear bit. A full time-out period then follows.
- R6: With run-in-idle at 0, strobes that arrive while idle is high are not counted. With run-in-idle at 1, they are counted as usual.
- R7: The reset request stays high from the overflow until the next machine-cycle strobe, and then falls.
- R8: The overflow that raises the reset request also clears the whole control byte, enable included.
- R9: A change of the prescaler select while the watchdog is counting applies only after the current prescaler period completes. The timer never advances more than once per strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mc_tick | input | 1 | Machine-cycle strobe, one clock high per instruction cycle |
| idle | input | 1 | High while the controller is in idle mode |
| sfr_addr | input | 8 | Register address |
| sfr_wr | input | 1 | Register write strobe |
| sfr_wdata | input | 8 | Register write data |
| sfr_rdata | output | 8 | Register read data (combinational) |
| wdt_rst_req | output | 1 | Reset request pulse, one machine cycle long |

## Verification
The hardest case to reach from the ports is a prescaler select change in the middle of a prescaler period. The old ratio has to finish its period before the new one applies, and nothing outside the block shows where the prescaler stands. The bench enables with a ratio of 16, applies exactly five strobes, and then rewrites the select to ratio 2. The expected strobe count to time-out is 11 plus fifteen short periods. The bench uses a 4-bit timer so that every select code can be run to overflow and counted exactly.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam int SEL_W = 3;
   localparam int PRE_W = 8;   // widest prescaler ratio is 2^8

   // log2 of the divide ratio; codes 1 and 2 are deliberately swapped
   function automatic logic [3:0] ratio_log2(input logic [SEL_W-1:0] code);
      logic [3:0] r;
      case (code)
         3'd1:    r = 4'd3;
         3'd2:    r = 4'd2;
         default: r = 4'({1'b0, code}) + 4'd1;
      endcase
      return r;
   endfunction
endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
   import wdt_pkg::*;
#(
   parameter int AW = 8,
   parameter int DW = 8,
   parameter logic [AW-1:0] REG_ADDR = 8'h8F
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mc_tick,
   input  logic             fire,
   input  logic [AW-1:0]    sfr_addr,
   input  logic             sfr_wr,
   input  logic [DW-1:0]    sfr_wdata,
   output logic [DW-1:0]    sfr_rdata,
   output logic             en_q,
   output logic             clr_q,
   output logic             idl_q,
   output logic [SEL_W-1:0] sel_q
);
   localparam int EN_B  = DW - 1;
   localparam int CLR_B = DW - 2;
   localparam int IDL_B = DW - 3;

   if (DW != 8) begin : g_bad_dw
      $error("wdt_ctrl_reg: DW must be 8");
   end

   logic hit;
   assign hit = (sfr_addr == REG_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         clr_q <= 1'b0;
         idl_q <= 1'b0;
         sel_q <= '0;
      end else if (fire) begin
         en_q  <= 1'b0;
         clr_q <= 1'b0;
         idl_q <= 1'b0;
         sel_q <= '0;
      end else begin
         clr_q <= (clr_q & ~mc_tick) | (sfr_wr & hit & sfr_wdata[CLR_B]);
         if (sfr_wr && hit) begin
            en_q  <= sfr_wdata[EN_B];
            idl_q <= sfr_wdata[IDL_B];
            sel_q <= sfr_wdata[SEL_W-1:0];
         end
      end
   end

   always_comb begin
      sfr_rdata = '0;
      if (hit) begin
         sfr_rdata[EN_B]        = en_q;
         sfr_rdata[CLR_B]       = clr_q;
         sfr_rdata[IDL_B]       = idl_q;
         sfr_rdata[SEL_W-1:0]   = sel_q;
      end
   end

   // R5
   clr_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_q && mc_tick && !(sfr_wr && hit && sfr_wdata[CLR_B])) |=> !clr_q);
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
   import wdt_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mc_tick,
   input  logic             run,
   input  logic             clr_go,
   input  logic [SEL_W-1:0] sel,
   output logic             step
);
   logic [PRE_W-1:0] pre_q;
   logic [SEL_W-1:0] sel_act;
   logic [PRE_W-1:0] lim;

   assign lim  = PRE_W'((32'd1 << ratio_log2(sel_act)) - 32'd1);
   assign step = mc_tick && run && !clr_go && (pre_q == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q   <= '0;
         sel_act <= '0;
      end else begin
         if (pre_q == '0)
            sel_act <= sel;
         if (clr_go)
            pre_q <= '0;
         else if (step)
            pre_q <= '0;
         else if (mc_tick && run)
            pre_q <= pre_q + 1'b1;
      end
   end

   // R4 / R6
   pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !clr_go) |=> $stable(pre_q));
   // R9
   sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_q != '0) |=> $stable(sel_act));
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer #(
   parameter int TMR_W = 14
)(
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   input  logic clr_go,
   output logic fire
);
   if (TMR_W < 2) begin : g_bad_tw
      $error("wdt_timer: TMR_W must be at least 2");
   end

   logic [TMR_W-1:0] tmr_q;

   assign fire = step && (&tmr_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tmr_q <= '0;
      else if (clr_go)
         tmr_q <= '0;
      else if (step)
         tmr_q <= tmr_q + 1'b1;
   end

   // R9
   tmr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clr_go) |=> (tmr_q == TMR_W'($past(tmr_q) + 1'b1)));
   // R5
   tmr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_go |=> (tmr_q == '0));
   // R4
   tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !clr_go) |=> $stable(tmr_q));
endmodule

// File: rtl/wdt_prescaled.sv
module wdt_prescaled
   import wdt_pkg::*;
#(
   parameter int TMR_W = 14,
   parameter logic [7:0] REG_ADDR = 8'h8F
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mc_tick,
   input  logic       idle,
   input  logic [7:0] sfr_addr,
   input  logic       sfr_wr,
   input  logic [7:0] sfr_wdata,
   output logic [7:0] sfr_rdata,
   output logic       wdt_rst_req
);
   logic             en_q, clr_q, idl_q, run, clr_go, step, fire;
   logic [SEL_W-1:0] sel_q;

   assign run    = en_q && (!idle || idl_q) && !wdt_rst_req;
   assign clr_go = clr_q && mc_tick;

   wdt_ctrl_reg #(.AW(8), .DW(8), .REG_ADDR(REG_ADDR)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .fire(fire),
      .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata),
      .sfr_rdata(sfr_rdata), .en_q(en_q), .clr_q(clr_q),
      .idl_q(idl_q), .sel_q(sel_q)
   );

   wdt_prescaler u_pre (
      .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .run(run),
      .clr_go(clr_go), .sel(sel_q), .step(step)
   );

   wdt_timer #(.TMR_W(TMR_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .step(step), .clr_go(clr_go), .fire(fire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wdt_rst_req <= 1'b0;
      else if (fire)
         wdt_rst_req <= 1'b1;
      else if (mc_tick)
         wdt_rst_req <= 1'b0;
   end

   // R7
   req_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wdt_rst_req && mc_tick) |=> !wdt_rst_req);
   // R8
   req_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wdt_rst_req) |-> !en_q);
   // R4
   req_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wdt_rst_req) |-> $past(en_q));
endmodule

// File: tb/wdt_prescaled_tb.sv
module wdt_prescaled_tb;
   localparam int TW = 4;
   localparam int TSPAN = 1 << TW;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mc_tick = 1'b0;
   logic       idle = 1'b0;
   logic [7:0] sfr_addr = 8'h8F;
   logic       sfr_wr = 1'b0;
   logic [7:0] sfr_wdata = 8'h00;
   logic [7:0] sfr_rdata;
   logic       wdt_rst_req;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   wdt_prescaled #(.TMR_W(TW), .REG_ADDR(8'h8F)) u_dut (
      .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .idle(idle),
      .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata),
      .sfr_rdata(sfr_rdata), .wdt_rst_req(wdt_rst_req)
   );

   function automatic int ratio_of(input int code);
      if (code == 1) return 8;
      if (code == 2) return 4;
      return 2 << code;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      mc_tick = 1'b0;
      sfr_wr = 1'b0;
      idle = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk);
      sfr_addr = 8'h8F;
      sfr_wdata = d;
      sfr_wr = 1'b1;
      @(negedge clk);
      sfr_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output int v);
      @(negedge clk);
      sfr_addr = a;
      #1 v = int'(sfr_rdata);
      sfr_addr = 8'h8F;
   endtask

   task automatic tick();
      @(negedge clk);
      mc_tick = 1'b1;
      @(negedge clk);
      mc_tick = 1'b0;
   endtask

   // apply strobes until the request shows; return the count (limit+1 if none)
   task automatic run_until(input int limit, output int cnt);
      cnt = limit + 1;
      for (int i = 1; i <= limit; i++) begin
         tick();
         if (wdt_rst_req) begin
            cnt = i;
            break;
         end
      end
   endtask

   initial begin
      int v, c, ex;
      do_reset();
      // R2
      rd(8'h8F, v);
      check("R2 reg", v, 0);
      check("R2 req", int'(wdt_rst_req), 0);

      // R1: bits 4:3 dropped, other address reads 0
      wr(8'h3D);
      rd(8'h8F, v);
      check("R1 layout", v, 8'h25);
      rd(8'h8E, v);
      check("R1 other addr", v, 0);

      // R3 / R7 / R8 sweep of all select codes
      for (int s = 0; s < 8; s++) begin
         do_reset();
         wr(8'h80 | 8'(s));
         ex = ratio_of(s) * TSPAN;
         run_until(ex + 4, c);
         check($sformatf("R3 sel%0d", s), c, ex);
         rd(8'h8F, v);
         check("R8 cleared", v, 0);
         check("R7 held", int'(wdt_rst_req), 1);
         tick();
         check("R7 fall", int'(wdt_rst_req), 0);
      end

      // R4 disabled
      do_reset();
      wr(8'h00);
      run_until(3 * TSPAN, c);
      check("R4 no req", c, 3 * TSPAN + 1);

      // R5 clear
      do_reset();
      wr(8'h80);
      for (int i = 0; i < 20; i++) tick();
      wr(8'hC0);
      rd(8'h8F, v);
      check("R5 pending", v, 8'hC0);
      tick();
      rd(8'h8F, v);
      check("R5 self clear", v, 8'h80);
      run_until(2 * TSPAN + 4, c);
      check("R5 restart", c, 2 * TSPAN);

      // R6 idle without run-in-idle
      do_reset();
      wr(8'h80);
      idle = 1'b1;
      for (int i = 0; i < 50; i++) tick();
      check("R6 frozen", int'(wdt_rst_req), 0);
      idle = 1'b0;
      run_until(2 * TSPAN + 4, c);
      check("R6 resume", c, 2 * TSPAN);

      // R6 idle with run-in-idle
      do_reset();
      wr(8'hA0);
      idle = 1'b1;
      run_until(2 * TSPAN + 4, c);
      check("R6 run idle", c, 2 * TSPAN);
      idle = 1'b0;

      // R9 select change mid-period: 16-ratio period finishes, then ratio 2
      do_reset();
      wr(8'h83);
      for (int i = 0; i < 5; i++) tick();
      wr(8'h80);
      ex = 11 + (TSPAN - 1) * 2;
      run_until(ex + 4, c);
      check("R9 switch", c, ex);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (150000) @(posedge clk);
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule